// File: doc/BRIEF.md
# Tiny Stored-Program 8-bit Processor

This block is a small multicycle processor that executes a program kept in its own 256-byte memory. It holds sixteen 8-bit general registers (R0 to RF), an 8-bit program counter and a 16-bit instruction register. Every instruction is two bytes long. The top hex digit is the operation code and the remaining three digits are operands whose meaning depends on that code. The memory is one byte wide, so each instruction takes two read cycles to fetch.

A bench or a boot agent fills the memory through the preload port while reset is held. The program runs from address 00 once reset is released. When the program reaches a halt, the `halted` output goes high and stays high. After that, the registers and memory can be inspected through the debug read ports, which are combinational and have no side effects.

The controller walks through five named states. FETCH_HI reads the byte at PC into the upper half of the instruction register and always moves to FETCH_LO. FETCH_LO reads the byte at PC+1 into the lower half, adds 2 to PC, and moves to DECODE. DECODE latches the operation code and moves to EXEC. EXEC performs the operation and then moves either back to FETCH_HI, or to HALT when the code is a halt or an undefined code. HALT only returns to itself. Synchronous reset forces FETCH_HI.

Top module: `tiny_cpu`

## Requirements
- R1: While reset is asserted at a clock edge, PC becomes 00, all sixteen registers become 00, and both `halted` and `illegal` read 0.
- R2: Code 2RXY writes the byte XY into register R (2356 leaves 56 in R3).
- R3: Code 1RXY writes the contents of memory cell XY into register R.
- R4: Code 3RXY writes register R into memory cell XY. A program 1402, 3417, C000 at address 00 leaves 34 in cell 17.
- R5: Code 40RS copies register R (digit 2) into register S (digit 3), so 4034 copies R3 into R4.
- R6: Code 5RST writes the sum of RS and RT, modulo 256, into RR.
- R7: Codes 7RST, 8RST and 9RST write RS OR RT, RS AND RT and RS XOR RT into RR.
- R8: Code AR0X rotates register R right by X mod 8 bit positions (0F rotated by 2 gives C3).
- R9: Code BRXY loads PC with XY when register R equals R0. Otherwise execution continues with the next instruction.
- R10: Code C000 enters HALT with `illegal` at 0. Once halted, `halted` stays 1 and PC, registers and memory stay unchanged until reset.
- R11: Codes 0, 6, D, E and F enter HALT with `illegal` set to 1 and change no register.
- R12: Each instruction takes four cycles (FETCH_HI, FETCH_LO, DECODE, EXEC). PC grows by 2 in FETCH_LO. For a program of N instructions ending in a halt, `halted` rises at the 4N-th clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halted | output | 1 | High while in the HALT state |
| illegal | output | 1 | High after halting on an undefined code |
| load_en | input | 1 | Preload write strobe for the memory |
| load_addr | input | 8 | Preload byte address |
| load_data | input | 8 | Preload byte value |
| dbg_reg_sel | input | 4 | Register index for the debug read |
| dbg_reg_data | output | 8 | Selected register value |
| dbg_mem_addr | input | 8 | Memory address for the debug read |
| dbg_mem_data | output | 8 | Selected memory byte |

## Verification
The only timed result is `halted`. It is due exactly 4N clock edges after reset is released for a program of N executed instructions, counting both taken and skipped jumps. The bench counts rising edges from the release and compares the count with 4N. It samples 1 ns after each edge, so the value read is the one the edge just registered. Register and memory results are pushed into a scoreboard queue when a program is launched. They are popped and compared through the debug ports only after `halted` is seen, at which point no further state can change.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int INSTR_W = 16;

    typedef enum logic [2:0] {
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_DECODE,
        ST_EXEC,
        ST_HALT
    } phase_t;

    localparam logic [3:0] OPC_LDM  = 4'h1;
    localparam logic [3:0] OPC_LDI  = 4'h2;
    localparam logic [3:0] OPC_STM  = 4'h3;
    localparam logic [3:0] OPC_MOV  = 4'h4;
    localparam logic [3:0] OPC_ADD  = 4'h5;
    localparam logic [3:0] OPC_OR   = 4'h7;
    localparam logic [3:0] OPC_AND  = 4'h8;
    localparam logic [3:0] OPC_XOR  = 4'h9;
    localparam logic [3:0] OPC_ROR  = 4'hA;
    localparam logic [3:0] OPC_JEQ  = 4'hB;
    localparam logic [3:0] OPC_HALT = 4'hC;

    function automatic logic opc_defined(input logic [3:0] opc);
        return (opc inside {OPC_LDM, OPC_LDI, OPC_STM, OPC_MOV, OPC_ADD, OPC_OR,
                            OPC_AND, OPC_XOR, OPC_ROR, OPC_JEQ, OPC_HALT});
    endfunction

endpackage

// File: rtl/cpu_mem.sv
module cpu_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata    = cells[raddr];
    assign dbg_data = cells[dbg_addr];
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  a_sel,
    output logic [DATA_W-1:0] a_data,
    input  logic [SEL_W-1:0]  b_sel,
    output logic [DATA_W-1:0] b_data,
    input  logic [SEL_W-1:0]  dbg_sel,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int NREG = 1 << SEL_W;

    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign a_data   = regs[a_sel];
    assign b_data   = regs[b_sel];
    assign dbg_data = regs[dbg_sel];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        opc,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        amt_field,
    output logic [DATA_W-1:0] y
);
    import cpu_pkg::*;

    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]     amt;
    logic [2*DATA_W-1:0] doubled;

    assign amt     = amt_field[SH_W-1:0];
    assign doubled = {a, a} >> amt;

    always_comb begin
        unique case (opc)
            OPC_ADD: y = a + b;
            OPC_OR:  y = a | b;
            OPC_AND: y = a & b;
            OPC_XOR: y = a ^ b;
            OPC_ROR: y = doubled[DATA_W-1:0];
            default: y = a;
        endcase
    end
endmodule

// File: rtl/tiny_cpu.sv
module tiny_cpu
    import cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic              halted,
    output logic              illegal,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [REG_AW-1:0] dbg_reg_sel,
    output logic [DATA_W-1:0] dbg_reg_data,
    input  logic [ADDR_W-1:0] dbg_mem_addr,
    output logic [DATA_W-1:0] dbg_mem_data
);
    localparam int IR_W = 2 * DATA_W;

    phase_t state_q, state_d;

    logic [ADDR_W-1:0] pc_q;
    logic [IR_W-1:0]   ir_q;
    logic [3:0]        opc_q;
    logic              illegal_q;

    logic [REG_AW-1:0] fld_r, fld_s, fld_t;
    logic [DATA_W-1:0] fld_imm;

    logic [ADDR_W-1:0] mem_raddr, mem_waddr;
    logic [DATA_W-1:0] mem_rdata, mem_wdata;
    logic              mem_we;

    logic [REG_AW-1:0] rf_a_sel, rf_b_sel, rf_waddr;
    logic [DATA_W-1:0] rf_a, rf_b, rf_wdata, alu_y;
    logic              rf_we;
    logic              in_exec, stop_now;

    assign fld_r   = ir_q[11:8];
    assign fld_s   = ir_q[7:4];
    assign fld_t   = ir_q[3:0];
    assign fld_imm = ir_q[7:0];
    assign in_exec = (state_q == ST_EXEC);
    assign stop_now = (opc_q == OPC_HALT) || !opc_defined(opc_q);

    // Memory address selection by phase
    always_comb begin
        unique case (state_q)
            ST_FETCH_HI: mem_raddr = pc_q;
            ST_FETCH_LO: mem_raddr = pc_q + ADDR_W'(1);
            default:     mem_raddr = fld_imm;
        endcase
    end

    assign mem_we    = load_en || (in_exec && opc_q == OPC_STM);
    assign mem_waddr = load_en ? load_addr : fld_imm;
    assign mem_wdata = load_en ? load_data : rf_a;

    // Register operand selection
    assign rf_a_sel = (opc_q == OPC_MOV || opc_q == OPC_ADD || opc_q == OPC_OR ||
                       opc_q == OPC_AND || opc_q == OPC_XOR) ? fld_s : fld_r;
    assign rf_b_sel = (opc_q == OPC_JEQ) ? '0 : fld_t;

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = fld_r;
        rf_wdata = alu_y;
        if (in_exec) begin
            unique case (opc_q)
                OPC_LDM: begin rf_we = 1'b1; rf_wdata = mem_rdata; end
                OPC_LDI: begin rf_we = 1'b1; rf_wdata = fld_imm; end
                OPC_MOV: begin rf_we = 1'b1; rf_waddr = fld_t; rf_wdata = rf_a; end
                OPC_ADD, OPC_OR, OPC_AND, OPC_XOR, OPC_ROR: rf_we = 1'b1;
                default: rf_we = 1'b0;
            endcase
        end
    end

    cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata),
        .dbg_addr(dbg_mem_addr), .dbg_data(dbg_mem_data)
    );

    cpu_regfile #(.SEL_W(REG_AW), .DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .a_sel(rf_a_sel), .a_data(rf_a), .b_sel(rf_b_sel), .b_data(rf_b),
        .dbg_sel(dbg_reg_sel), .dbg_data(dbg_reg_data)
    );

    cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .opc(opc_q), .a(rf_a), .b(rf_b), .amt_field(fld_t), .y(alu_y)
    );

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_FETCH_HI: state_d = ST_FETCH_LO;
            ST_FETCH_LO: state_d = ST_DECODE;
            ST_DECODE:   state_d = ST_EXEC;
            ST_EXEC:     state_d = stop_now ? ST_HALT : ST_FETCH_HI;
            default:     state_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH_HI;
        else     state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            ir_q      <= '0;
            opc_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH_HI: ir_q[IR_W-1:DATA_W] <= mem_rdata;
                ST_FETCH_LO: begin
                    ir_q[DATA_W-1:0] <= mem_rdata;
                    pc_q             <= pc_q + ADDR_W'(2);
                end
                ST_DECODE:   opc_q <= ir_q[IR_W-1 -: 4];
                ST_EXEC: begin
                    if (opc_q == OPC_JEQ && rf_a == rf_b) pc_q <= fld_imm;
                    if (!opc_defined(opc_q)) illegal_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign halted  = (state_q == ST_HALT);
    assign illegal = illegal_q;
endmodule

// File: rtl/cpu_checker.sv
module cpu_checker
    import cpu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic              illegal,
    input phase_t            state,
    input logic [ADDR_W-1:0] pc
);
    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R1
    always @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            reset_state_chk: assert (pc == '0 && !halted && !illegal && state == ST_FETCH_HI)
                else $error("reset state wrong");
        end
    end

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));

    // R11
    illegal_halts_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);

    // R12
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_HI) |=> (state == ST_FETCH_LO));

    // R12
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_LO) |=> (pc == ADDR_W'($past(pc) + ADDR_W'(2))));
endmodule

bind tiny_cpu cpu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .halted(halted), .illegal(illegal),
    .state(state_q), .pc(pc_q)
);

// File: tb/tiny_cpu_tb.sv
`timescale 1ns/1ps
module tiny_cpu_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halted, illegal;
    logic       load_en = 1'b0;
    logic [7:0] load_addr = '0, load_data = '0;
    logic [3:0] dbg_reg_sel = '0;
    logic [7:0] dbg_reg_data;
    logic [7:0] dbg_mem_addr = '0;
    logic [7:0] dbg_mem_data;

    always #2.5 clk = ~clk;

    tiny_cpu u_dut (
        .clk(clk), .rst(rst), .halted(halted), .illegal(illegal),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data)
    );

    typedef struct {
        bit         is_mem;
        logic [7:0] addr;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t        sbq[$];
    logic [15:0] prog[$];
    int          n_cmp = 0;
    int          n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver side: queue an expected register or memory value
    task automatic expect_reg(input logic [3:0] r, input logic [7:0] v, input string tag);
        exp_t e;
        e.is_mem = 1'b0; e.addr = {4'h0, r}; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic expect_mem(input logic [7:0] a, input logic [7:0] v, input string tag);
        exp_t e;
        e.is_mem = 1'b1; e.addr = a; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor side: pop and compare through the debug ports
    task automatic drain_scoreboard();
        while (sbq.size() > 0) begin
            exp_t e = sbq.pop_front();
            if (e.is_mem) begin
                dbg_mem_addr = e.addr; #1;
                chk({e.tag, " mem"}, {24'h0, dbg_mem_data}, {24'h0, e.val});
            end else begin
                dbg_reg_sel = e.addr[3:0]; #1;
                chk({e.tag, " reg"}, {24'h0, dbg_reg_data}, {24'h0, e.val});
            end
        end
    endtask

    task automatic run_prog(input int n_instr, input logic exp_illegal, input string tag);
        int cyc = 0;
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 256; a++) begin
            load_en = 1'b1; load_addr = 8'(a); load_data = 8'h00;
            @(negedge clk);
        end
        for (int i = 0; i < prog.size(); i++) begin
            load_addr = 8'(2 * i);     load_data = prog[i][15:8]; @(negedge clk);
            load_addr = 8'(2 * i + 1); load_data = prog[i][7:0];  @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        while (cyc < 2000) begin
            @(posedge clk); #1;
            cyc++;
            if (halted) break;
        end
        // R12: halt due 4N edges after release
        chk({tag, " R12 halt cycle"}, cyc, 4 * n_instr);
        chk({tag, " R10/R11 illegal flag"}, {31'h0, illegal}, {31'h0, exp_illegal});
        drain_scoreboard();
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // P1: load from memory then store (R3, R4, R10)
        prog = '{16'h1402, 16'h3417, 16'hC000};
        expect_reg(4'h4, 8'h34, "R3 load from cell");
        expect_mem(8'h17, 8'h34, "R4 store to cell 17");
        run_prog(3, 1'b0, "P1 R10");

        // P2: immediates, move, arithmetic, logic, rotate (R2, R5-R8)
        prog = '{16'h2356, 16'h4034, 16'h2A0F, 16'hAA02, 16'h21C8, 16'h2250,
                 16'h5512, 16'h7612, 16'h8712, 16'h9812, 16'h2B81, 16'hAB0A, 16'hC000};
        expect_reg(4'h3, 8'h56, "R2 immediate");
        expect_reg(4'h4, 8'h56, "R5 move");
        expect_reg(4'hA, 8'hC3, "R8 rotate by 2");
        expect_reg(4'h5, 8'h18, "R6 add wraps");
        expect_reg(4'h6, 8'hD8, "R7 or");
        expect_reg(4'h7, 8'h40, "R7 and");
        expect_reg(4'h8, 8'h98, "R7 xor");
        expect_reg(4'hB, 8'h60, "R8 rotate amount mod 8");
        expect_reg(4'h1, 8'hC8, "R2 immediate C8");
        run_prog(13, 1'b0, "P2");

        // R1: reset clears registers and flags
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 halted after reset", {31'h0, halted}, 32'h0);
        chk("R1 illegal after reset", {31'h0, illegal}, 32'h0);
        for (int r = 0; r < 16; r++) begin
            dbg_reg_sel = 4'(r); #0.1;
            chk("R1 register cleared", {24'h0, dbg_reg_data}, 32'h0);
        end

        // P3: jump not taken then taken (R9)
        prog = '{16'h2107, 16'hB10A, 16'h2AAA, 16'h2005, 16'h2205,
                 16'hB210, 16'h2955, 16'hC000, 16'h2C33, 16'hC000};
        expect_reg(4'hA, 8'hAA, "R9 fall through");
        expect_reg(4'h9, 8'h00, "R9 skipped instruction");
        expect_reg(4'hC, 8'h33, "R9 jump target");
        run_prog(8, 1'b0, "P3 R9");

        // P4: opcode 6 is illegal, then halt is frozen (R11, R10)
        prog = '{16'h2155, 16'h6000, 16'h2166};
        expect_reg(4'h1, 8'h55, "R11 op6 no later write");
        run_prog(2, 1'b1, "P4 R11");
        repeat (20) @(posedge clk);
        #1;
        chk("R10 still halted", {31'h0, halted}, 32'h1);
        dbg_reg_sel = 4'h1; #1;
        chk("R10 register frozen", {24'h0, dbg_reg_data}, 32'h55);

        // P5: opcode E illegal (R11)
        prog = '{16'h2177, 16'hE123, 16'h2188};
        expect_reg(4'h1, 8'h77, "R11 opE");
        run_prog(2, 1'b1, "P5 R11");

        // P6: opcode 0 illegal (R11)
        prog = '{16'h0000};
        expect_reg(4'h0, 8'h00, "R11 op0");
        run_prog(1, 1'b1, "P6 R11");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule